// File: doc/BRIEF.md
# Packed Lane-Wise Bidirectional Shifter

This block shifts every lane of a 128-bit data vector by its own amount. The amount comes from the matching lane of a second 128-bit control vector. A two-bit selector splits both vectors into 8, 16, 32 or 64-bit lanes. Each lane's count is a signed byte, and its sign sets the direction. A count of zero or more shifts the lane left. A negative count shifts it right. A mode input chooses a logical or an arithmetic right shift.

Counts at or beyond the lane width never wrap. They give zero, or fill the lane with its sign bit when an arithmetic right shift is selected. A half-width input limits an operation to 64 bits, and the upper half of the result is then zero. The result and its valid flag are registered one clock after the input strobe. There is no handshake on either side.

Top module: `vshift_top`

## Requirements
- R1: A lane's count is the least significant 8 bits of its control lane, taken as two's complement (-128 to +127). All higher control bits of that lane have no effect on the result.
- R2: A count from 0 to lane width minus 1 shifts the lane left by that count and fills the vacated low bits with zeros.
- R3: With is_signed=0, a negative count whose magnitude is below the lane width shifts the lane right logically by that magnitude.
- R4: A count of zero or more that is equal to or larger than the lane width gives an all-zero lane, in both modes.
- R5: With is_signed=0, a negative count whose magnitude is equal to or larger than the lane width gives an all-zero lane.
- R6: With is_signed=1, a negative count shifts the lane right arithmetically. A magnitude equal to or larger than the lane width is clamped to width minus 1, so the lane becomes copies of its sign bit.
- R7: lane_size encodes 00=8, 01=16, 10=32 and 11=64-bit lanes. Lane 0 sits at the least significant end, and no bit crosses a lane boundary in either direction.
- R8: With half_width=1, result[127:64] is zero.
- R9: result and out_valid are registered. out_valid equals in_valid from the previous clock. result loads only when in_valid is 1 and holds otherwise.
- R10: While rst_n is low at a clock edge, result and out_valid are cleared (synchronous, active low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands are present this cycle |
| data | input | 128 | Data vector to be shifted |
| shamt | input | 128 | Per-lane shift control vector |
| lane_size | input | 2 | Lane width select: 00=8, 01=16, 10=32, 11=64 |
| is_signed | input | 1 | 1 selects arithmetic right shift and sign fill |
| half_width | input | 1 | 1 forces the upper 64 result bits to zero |
| result | output | 128 | Registered shifted vector |
| out_valid | output | 1 | result was loaded in the previous cycle |

## Verification
The bench builds the block with its defaults: a 128-bit vector and an 8-bit count field. These values bring all four lane sizes within reach, from sixteen 8-bit lanes down to two 64-bit lanes. They also allow every count from -128 to +127. Counts near the lane width are the interesting ones: one less than the width, exactly the width, and -128 against every lane width. In the sweep each lane gets a different count and random bits above its count byte, so any leakage between neighbouring lanes or from the upper control bits would show.

// File: rtl/vshift_pkg.sv
package vshift_pkg;
    localparam int BASE_LANE_W = 8;
    localparam int NUM_SIZES   = 4;

    typedef enum logic [1:0] {
        LS_B8  = 2'b00,
        LS_B16 = 2'b01,
        LS_B32 = 2'b10,
        LS_B64 = 2'b11
    } lane_size_e;
endpackage

// File: rtl/vshift_lane.sv
module vshift_lane #(
    parameter int LANE_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic [LANE_W-1:0] din,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              arith,
    output logic [LANE_W-1:0] dout
);
    localparam int MAG_W = CNT_W + 1;

    logic             neg;
    logic [MAG_W-1:0] mag;
    logic             too_far;
    logic [MAG_W-1:0] rsh;

    always_comb begin
        neg     = cnt[CNT_W-1];
        mag     = neg ? (MAG_W'(0) - {1'b1, cnt}) : {1'b0, cnt};
        too_far = (int'(mag) >= LANE_W);
        rsh     = too_far ? MAG_W'(LANE_W - 1) : mag;
        if (!neg) begin
            dout = too_far ? '0 : (din << mag);
        end else if (arith) begin
            dout = LANE_W'($signed(din) >>> rsh);
        end else begin
            dout = too_far ? '0 : (din >> mag);
        end
    end

    // Lane-level checks on out-of-range counts
    always_comb begin
        if (!neg && too_far) begin
            assert_left_zero_R4: assert (dout == '0);
        end
        if (neg && too_far && !arith) begin
            assert_right_zero_R5: assert (dout == '0);
        end
        if (neg && too_far && arith) begin
            assert_sign_fill_R6: assert (dout == {LANE_W{din[LANE_W-1]}});
        end
    end
endmodule

// File: rtl/vshift_array.sv
module vshift_array #(
    parameter int VEC_W = 128,
    parameter int CNT_W = 8
) (
    input  logic [VEC_W-1:0]          data,
    input  logic [VEC_W-1:0]          shamt,
    input  vshift_pkg::lane_size_e    size,
    input  logic                      arith,
    input  logic                      half,
    output logic [VEC_W-1:0]          res
);
    import vshift_pkg::*;

    localparam int HALF_W = VEC_W / 2;

    logic [NUM_SIZES-1:0][VEC_W-1:0] per_size;

    for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
        localparam int LW = BASE_LANE_W << s;
        localparam int NL = VEC_W / LW;
        for (genvar l = 0; l < NL; l++) begin : g_lane
            vshift_lane #(.LANE_W(LW), .CNT_W(CNT_W)) u_lane (
                .din  (data[l*LW +: LW]),
                .cnt  (shamt[l*LW +: CNT_W]),
                .arith(arith),
                .dout (per_size[s][l*LW +: LW])
            );
        end
    end

    always_comb begin
        res = per_size[size];
        if (half) begin
            res[VEC_W-1:HALF_W] = '0;
        end
    end
endmodule

// File: rtl/vshift_top.sv
module vshift_top #(
    parameter int VEC_W = 128,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [VEC_W-1:0] data,
    input  logic [VEC_W-1:0] shamt,
    input  logic [1:0]       lane_size,
    input  logic             is_signed,
    input  logic             half_width,
    output logic [VEC_W-1:0] result,
    output logic             out_valid
);
    import vshift_pkg::*;

    localparam int HALF_W = VEC_W / 2;

    typedef struct packed {
        logic             valid;
        logic [VEC_W-1:0] res;
    } state_t;

    state_t           st_d, st_q;
    logic [VEC_W-1:0] shifted;

    vshift_array #(.VEC_W(VEC_W), .CNT_W(CNT_W)) u_array (
        .data (data),
        .shamt(shamt),
        .size (lane_size_e'(lane_size)),
        .arith(is_signed),
        .half (half_width),
        .res  (shifted)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.res = shifted;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result    = st_q.res;
    assign out_valid = st_q.valid;

    assert_valid_lat_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));
    assert_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && half_width) |=> (result[VEC_W-1:HALF_W] == '0));
    assert_reset_clear_R10: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && result == '0));
endmodule

// File: tb/vshift_top_bench.sv
module vshift_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 11;

    typedef struct packed {
        logic [1:0]   sz;
        logic         sg;
        logic         hf;
        logic [127:0] d;
        logic [127:0] s;
        logic [127:0] e;
    } vec_t;

    localparam vec_t TABLE [NV] = '{
        '{2'd0, 1'b0, 1'b0, {16{8'h81}}, {16{8'h01}}, {16{8'h02}}},                       // R2
        '{2'd0, 1'b1, 1'b0, {16{8'h81}}, {16{8'hFF}}, {16{8'hC0}}},                       // R6
        '{2'd0, 1'b0, 1'b0, {16{8'h81}}, {16{8'hFF}}, {16{8'h40}}},                       // R3
        '{2'd1, 1'b0, 1'b0, {8{16'h00F0}}, {8{16'hAB04}}, {8{16'h0F00}}},                 // R1
        '{2'd2, 1'b1, 1'b0, {4{32'h8000_0000}}, {4{32'h0000_0080}}, {4{32'hFFFF_FFFF}}},  // R6
        '{2'd2, 1'b0, 1'b0, {4{32'h8000_0000}}, {4{32'h0000_0080}}, 128'h0},              // R5
        '{2'd3, 1'b0, 1'b0, {2{64'h1}}, {2{64'h3F}}, {2{64'h8000_0000_0000_0000}}},       // R2
        '{2'd3, 1'b1, 1'b0, {2{64'h1}}, {2{64'h40}}, 128'h0},                             // R4
        '{2'd1, 1'b1, 1'b1, {8{16'h8001}}, {8{16'h0001}}, {64'h0, {4{16'h0002}}}},        // R8
        '{2'd0, 1'b0, 1'b0, {16{8'hFF}}, {16{8'h04}}, {16{8'hF0}}},                       // R7
        '{2'd0, 1'b0, 1'b0, {16{8'hFF}}, {16{8'hFC}}, {16{8'h0F}}}                        // R7
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] data = '0;
    logic [127:0] shamt = '0;
    logic [1:0]   lane_size = '0;
    logic         is_signed = 1'b0;
    logic         half_width = 1'b0;
    logic [127:0] result;
    logic         out_valid;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vshift_top u_vshift_top (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .data(data), .shamt(shamt),
        .lane_size(lane_size), .is_signed(is_signed), .half_width(half_width),
        .result(result), .out_valid(out_valid)
    );

    function automatic logic [127:0] ref_shift(logic [127:0] d, logic [127:0] c,
                                               logic [1:0] sz, logic sg, logic hf);
        logic [127:0] acc = '0;
        int lw = 8 << sz;
        for (int l = 0; l < 128 / lw; l++) begin
            logic [63:0] v;
            logic [63:0] r;
            logic [63:0] msk;
            logic signed [63:0] sv;
            logic [7:0] cb;
            int n;
            msk = (lw == 64) ? '1 : ((64'd1 << lw) - 64'd1);
            v   = 64'(d >> (l * lw)) & msk;
            cb  = 8'(c >> (l * lw));
            n   = int'($signed(cb));
            if (n >= 0) begin
                r = (n >= lw) ? 64'd0 : (v << n);
            end else if (sg) begin
                sv = $signed(v << (64 - lw)) >>> (64 - lw);
                r  = 64'(sv >>> (((-n) >= lw) ? (lw - 1) : (-n)));
            end else begin
                r = ((-n) >= lw) ? 64'd0 : (v >> (-n));
            end
            acc = acc | (128'(r & msk) << (l * lw));
        end
        if (hf) acc[127:64] = '0;
        return acc;
    endfunction

    task automatic check(string req, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(logic [127:0] d, logic [127:0] s, logic [1:0] sz, logic sg, logic hf);
        @(negedge clk);
        data = d; shamt = s; lane_size = sz; is_signed = sg; half_width = hf; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL R9 watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R10 reset result", result, '0);
        check("R10 reset valid", {127'd0, out_valid}, 128'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(TABLE[i].d, TABLE[i].s, TABLE[i].sz, TABLE[i].sg, TABLE[i].hf);
            check($sformatf("R1-table entry %0d (R2 R3 R6 R7 R8)", i), result, TABLE[i].e);
        end

        // R9: valid one cycle, result held while idle
        apply({16{8'h11}}, {16{8'h01}}, 2'd0, 1'b0, 1'b0);
        check("R9 valid after strobe", {127'd0, out_valid}, 128'd1);
        @(negedge clk);
        check("R9 valid drops", {127'd0, out_valid}, 128'd0);
        data = '1;
        @(negedge clk);
        check("R9 result held", result, {16{8'h22}});

        // R4: left by exactly lane width minus one and width in 8-bit lanes
        apply({16{8'h01}}, {16{8'h07}}, 2'd0, 1'b0, 1'b0);
        check("R4 below width", result, {16{8'h80}});
        apply({16{8'h01}}, {16{8'h08}}, 2'd0, 1'b1, 1'b0);
        check("R4 at width", result, '0);

        // R6: positive lane under arithmetic far right shift
        apply({2{64'h7FFF_0000_0000_0000}}, {2{64'hFFFF_FFFF_FFFF_FF80}}, 2'd3, 1'b1, 1'b0);
        check("R6 positive fill", result, '0);

        // Sweep: every count, all sizes, both modes, distinct lane counts
        for (int sz = 0; sz < 4; sz++) begin
            for (int sg = 0; sg < 2; sg++) begin
                for (int cnt = -128; cnt < 128; cnt++) begin
                    logic [127:0] d;
                    logic [127:0] s;
                    logic [1:0]   szb;
                    int lw;
                    szb = 2'(sz);
                    lw = 8 << sz;
                    d = {$urandom, $urandom, $urandom, $urandom};
                    s = {$urandom, $urandom, $urandom, $urandom};
                    for (int l = 0; l < 128 / lw; l++) begin
                        s[l*lw +: 8] = 8'(cnt + l * 7);
                    end
                    apply(d, s, szb, sg[0], cnt[0] & cnt[3]);
                    check($sformatf("R1 R7 sweep sz=%0d sg=%0d cnt=%0d", sz, sg, cnt),
                          result, ref_shift(d, s, szb, sg[0], cnt[0] & cnt[3]));
                end
            end
        end

        // R10: reset after an operation clears outputs
        apply({16{8'h33}}, '0, 2'd0, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 reset clears result", result, '0);
        rst_n = 1'b1;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule